// File: doc/BRIEF.md
# Nested-Loop Instruction Sequencer

This block runs a short compiled program held in a small local store and emits a stream of control words, one per cycle whenever the program is emitting. A program has three kinds of entries. An emit entry drives one word onto the output for a given number of consecutive cycles. A loop entry repeats the entries that follow it, up to a given end address, a given number of times. A halt entry stops the run. Loop bookkeeping lives in dedicated registers: a trip count, a body start address and a body end address, with enclosing loops saved on a small stack. Jumping back to the start of the body, or leaving the loop, happens during the same cycle as the last word of the body. This means the only cost of a loop is the one cycle in which its loop entry executes.

Software writes the program through a load port while the sequencer is idle, then pulses `start`. A global `stall` freezes the sequencer so that a downstream stage can apply backpressure. The words go to a configurable control path that decodes them into the datapath's per-cycle control.

Top module: `nlp_ctrl`

## Requirements
- R1: Writing `prog_data` with `prog_we` high stores it at `prog_addr`. Entry layout: bits [17:16] hold the opcode (0 = halt, 1 = emit, 2 = loop, 3 acts as halt), bits [15:8] hold the count, and bits [7:0] hold the word (emit) or the loop's end address in bits [3:0]. `start` with the sequencer idle begins execution at address 0. `start` has no effect while a run is in progress.
- R2: An emit entry with count C puts its word on `word_out` with `word_valid` high for C consecutive unstalled cycles, then moves on. A count of 0 behaves as 1.
- R3: A loop entry with count C and end address E runs the entries from the next address through E, C times, and then falls through. A count of 0 behaves as 1. Loops nest. Each loop entry takes exactly one cycle with `word_valid` low. Without stalls, `halted` rises exactly W + L + 1 cycles after the start edge, where W is the number of words emitted and L is the number of loop entries executed.
- R4: When a loop finishes on an address that is also the end address of the loop directly enclosing it, the enclosing loop's end test applies to that same entry: it either jumps back to its own start or also finishes.
- R5: Up to 4 enclosing loops are saved. Entering a loop when 4 are already saved sets `stack_err`. `stack_err` stays high through later runs until reset.
- R6: While `stall` is high, the sequencer does not advance. Each stalled cycle gives `word_valid` low and leaves `word_out` unchanged. The word stream that follows is the same as it would have been without the stall.
- R7: A halt entry raises `halted`. `word_valid` then stays low until the next `start`.
- R8: After reset, `word_valid`, `halted` and `stack_err` are low and `word_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 4 | Program store write address |
| prog_data | input | 18 | Program entry to write |
| start | input | 1 | Begin a run at address 0 when idle |
| stall | input | 1 | Freeze the sequencer this cycle |
| word_out | output | 8 | Emitted control word (registered) |
| word_valid | output | 1 | `word_out` carries a new word this cycle |
| halted | output | 1 | A halt entry has executed |
| stack_err | output | 1 | Sticky loop-stack overflow |

## Verification
The bench runs the ten-entry shared-label program and randomised variants of it against a reference interpreter. A sequencer that gets the shared end label wrong would repeat the outer body with a stale count, or would run past the halt. Runs without stalls also check the exact cycle count. A design that spent an extra cycle on each jump back, or that let the repeat counter slip by one, would give the same words but a longer run, so only the cycle count catches it. Random stalls check that no word is dropped or duplicated and that the held word does not change. Directed programs cover counts of zero, five-deep nesting that fills the stack exactly, and six-deep nesting that must set the sticky overflow flag without corrupting the next run.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
  typedef enum logic [1:0] {
    OP_HALT = 2'd0,
    OP_EMIT = 2'd1,
    OP_LOOP = 2'd2,
    OP_RSVD = 2'd3
  } op_e;
endpackage

// File: rtl/nlp_imem.sv
module nlp_imem #(
  parameter int AW = 4,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << AW;
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // distributed-RAM style read so the fetch and the execute share a cycle
  assign rdata = mem[raddr];
endmodule

// File: rtl/nlp_repeat.sv
module nlp_repeat #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] rem;
  logic          first;

  assign first = (rem == '0);
  assign last  = first ? (cnt <= CW'(1)) : (rem == CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) rem <= '0;
    else if (en) begin
      if (first) rem <= (cnt > CW'(1)) ? cnt - CW'(1) : '0;
      else       rem <= rem - CW'(1);
    end
  end

  // R2: a repeat in flight always ends before the counter wraps
  a_r2_rem_drains: assert property (@(posedge clk) disable iff (rst)
    (en && !first && !clr) |=> (rem < $past(rem)));
endmodule

// File: rtl/nlp_lstack.sv
module nlp_lstack #(
  parameter int DEPTH = 4,
  parameter int EW    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       pop2,
  input  logic [EW-1:0]              din,
  output logic [EW-1:0]              top,
  output logic [EW-1:0]              nxt,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EW-1:0] mem [DEPTH];
  logic [SW-1:0] wr_i, top_i, nxt_i;

  assign wr_i  = SW'(level);
  assign top_i = SW'(level - LW'(1));
  assign nxt_i = SW'(level - LW'(2));
  assign top   = mem[top_i];
  assign nxt   = mem[nxt_i];

  always_ff @(posedge clk) begin
    if (push && level < LW'(DEPTH)) mem[wr_i] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) level <= '0;
    else if (push) begin
      if (level < LW'(DEPTH)) level <= level + LW'(1);
    end else if (pop2) level <= (level >= LW'(2)) ? level - LW'(2) : '0;
    else if (pop)      level <= (level != '0) ? level - LW'(1) : '0;
  end

  // R5: the saved-loop count never exceeds the stack depth
  a_r5_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  // R5: a push into a full stack leaves the level unchanged
  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
    (push && !clr && level == LW'(DEPTH)) |=> (level == LW'(DEPTH)));
endmodule

// File: rtl/nlp_ctrl.sv
module nlp_ctrl #(
  parameter int IW    = 8,
  parameter int CW    = 8,
  parameter int DEPTH = 16,
  parameter int STACK = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               prog_we,
  input  logic [$clog2(DEPTH)-1:0]           prog_addr,
  input  logic [2+CW+IW-1:0]                 prog_data,
  input  logic                               start,
  input  logic                               stall,
  output logic [IW-1:0]                      word_out,
  output logic                               word_valid,
  output logic                               halted,
  output logic                               stack_err
);
  import nlp_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = 2 + CW + IW;
  localparam int EW = CW + 2 * AW;
  localparam int LW = $clog2(STACK + 1);

  logic          run;
  logic [AW-1:0] pc, lbeg, lend;
  logic [CW-1:0] lcnt;
  logic          act;

  logic [PW-1:0] ins;
  op_e           op;
  logic [CW-1:0] icnt;
  logic [IW-1:0] ipay;
  logic [AW-1:0] itgt;

  nlp_imem #(.AW(AW), .DW(PW)) u_imem (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(pc), .rdata(ins)
  );

  assign op   = op_e'(ins[PW-1 -: 2]);
  assign icnt = ins[IW +: CW];
  assign ipay = ins[IW-1:0];
  assign itgt = ipay[AW-1:0];

  logic go, accept, rep_en, rep_last;
  assign accept = start && !run;
  assign go     = run && !stall;
  assign rep_en = go && (op == OP_EMIT);

  nlp_repeat #(.CW(CW)) u_rep (
    .clk(clk), .rst(rst), .clr(accept), .en(rep_en), .cnt(icnt), .last(rep_last)
  );

  logic          push, pop, pop2;
  logic [EW-1:0] stk_top, stk_nxt;
  logic [LW-1:0] lvl;

  nlp_lstack #(.DEPTH(STACK), .EW(EW)) u_stk (
    .clk(clk), .rst(rst), .clr(accept), .push(push), .pop(pop), .pop2(pop2),
    .din({lcnt, lbeg, lend}), .top(stk_top), .nxt(stk_nxt), .level(lvl)
  );

  logic [CW-1:0] t_cnt, n_cnt;
  logic [AW-1:0] t_beg, t_end, n_beg, n_end;
  assign {t_cnt, t_beg, t_end} = stk_top;
  assign {n_cnt, n_beg, n_end} = stk_nxt;

  logic [AW-1:0] pc_n, lbeg_n, lend_n;
  logic [CW-1:0] lcnt_n;
  logic          act_n, finish;

  always_comb begin
    pc_n   = pc;
    act_n  = act;
    lcnt_n = lcnt;
    lbeg_n = lbeg;
    lend_n = lend;
    push   = 1'b0;
    pop    = 1'b0;
    pop2   = 1'b0;
    finish = 1'b0;
    if (go) begin
      unique case (op)
        OP_LOOP: begin
          push   = act;
          act_n  = 1'b1;
          lcnt_n = (icnt == '0) ? CW'(1) : icnt;
          lbeg_n = pc + AW'(1);
          lend_n = itgt;
          pc_n   = pc + AW'(1);
        end
        OP_EMIT: begin
          if (rep_last) begin
            pc_n = pc + AW'(1);
            if (act && pc == lend) begin
              if (lcnt > CW'(1)) begin
                pc_n   = lbeg;
                lcnt_n = lcnt - CW'(1);
              end else if (lvl == '0) begin
                act_n = 1'b0;
              end else if (t_end == pc && t_cnt > CW'(1)) begin
                pop    = 1'b1;
                pc_n   = t_beg;
                lcnt_n = t_cnt - CW'(1);
                lbeg_n = t_beg;
                lend_n = t_end;
              end else if (t_end == pc) begin
                pop2 = 1'b1;
                if (lvl > LW'(1)) begin
                  lcnt_n = n_cnt;
                  lbeg_n = n_beg;
                  lend_n = n_end;
                end else begin
                  act_n = 1'b0;
                end
              end else begin
                pop    = 1'b1;
                lcnt_n = t_cnt;
                lbeg_n = t_beg;
                lend_n = t_end;
              end
            end
          end
        end
        default: finish = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      halted     <= 1'b0;
      pc         <= '0;
      act        <= 1'b0;
      lcnt       <= '0;
      lbeg       <= '0;
      lend       <= '0;
      stack_err  <= 1'b0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (accept) begin
        run    <= 1'b1;
        halted <= 1'b0;
        pc     <= '0;
        act    <= 1'b0;
      end else begin
        if (go) begin
          pc   <= pc_n;
          act  <= act_n;
          lcnt <= lcnt_n;
          lbeg <= lbeg_n;
          lend <= lend_n;
        end
        if (finish) begin
          run    <= 1'b0;
          halted <= 1'b1;
        end
        if (rep_en) begin
          word_out   <= ipay;
          word_valid <= 1'b1;
        end
        if (push && lvl == LW'(STACK)) stack_err <= 1'b1;
      end
    end
  end

  // R6: a stalled cycle moves nothing and emits nothing
  a_r6_stall_freeze: assert property (@(posedge clk) disable iff (rst)
    (run && stall) |=> (pc == $past(pc) && !word_valid && word_out == $past(word_out)));
  // R2: the fetch address holds until the final repeat of an emit entry
  a_r2_hold_pc: assert property (@(posedge clk) disable iff (rst)
    (rep_en && !rep_last) |=> (pc == $past(pc)));
  // R3: a loop entry costs one cycle with no word
  a_r3_setup_silent: assert property (@(posedge clk) disable iff (rst)
    (go && op == OP_LOOP) |=> !word_valid);
  // R5: the overflow flag never clears without reset
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    stack_err |=> stack_err);
  // R7: no word while halted
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !word_valid);
endmodule

// File: tb/nlp_ctrl_tb.sv
`timescale 1ns/1ps
module nlp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [3:0]  prog_addr = '0;
  logic [17:0] prog_data = '0;
  logic        start = 1'b0;
  logic        stall = 1'b0;
  logic [7:0]  word_out;
  logic        word_valid, halted, stack_err;

  always #2.5 clk = ~clk;

  nlp_ctrl u_dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .start(start), .stall(stall), .word_out(word_out),
    .word_valid(word_valid), .halted(halted), .stack_err(stack_err)
  );

  int n_chk = 0, n_bad = 0;
  int b_op [16];
  int b_cnt[16];
  int b_pay[16];
  logic [7:0] exp_w [16384];
  int n_exp, n_loops;
  bit m_ovf;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int one_min(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) begin b_op[i] = 0; b_cnt[i] = 0; b_pay[i] = 0; end
  endtask

  task automatic put(input int a, input int op, input int c, input int p);
    b_op[a] = op; b_cnt[a] = c; b_pay[a] = p;
  endtask

  // reference interpreter of the program semantics
  task automatic model();
    int pc, sp, act, lc, lb, le, steps;
    int sc[4], sb[4], se[4];
    bit adv;
    pc = 0; sp = 0; act = 0; lc = 0; lb = 0; le = 0; steps = 0;
    n_exp = 0; n_loops = 0; m_ovf = 0;
    while (steps < 100000) begin
      steps++;
      if (b_op[pc] == 1) begin
        for (int k = 0; k < one_min(b_cnt[pc]); k++) begin
          if (n_exp < 16384) exp_w[n_exp] = 8'(b_pay[pc]);
          n_exp++;
        end
        adv = 1;
        while (act != 0 && pc == le) begin
          if (lc > 1) begin lc--; pc = lb; adv = 0; break; end
          if (sp > 0) begin sp--; lc = sc[sp]; lb = sb[sp]; le = se[sp]; end
          else act = 0;
        end
        if (adv) pc = (pc + 1) % 16;
      end else if (b_op[pc] == 2) begin
        if (act != 0) begin
          if (sp < 4) begin sc[sp] = lc; sb[sp] = lb; se[sp] = le; sp++; end
          else m_ovf = 1;
        end
        act = 1; lc = one_min(b_cnt[pc]); lb = (pc + 1) % 16; le = b_pay[pc] % 16;
        n_loops++;
        pc = (pc + 1) % 16;
      end else break;
    end
  endtask

  task automatic load_prog();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 4'(i);
      prog_data = {2'(b_op[i]), 8'(b_cnt[i]), 8'(b_pay[i])};
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; stall = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // run the loaded program; compare words, stall behaviour and cycle count
  task automatic run_prog(input bit stall_en, input bit cyc_chk, input bit mid_start, input bit seq_chk);
    int n, idx;
    bit st_prev;
    logic [7:0] prev_w;
    model();
    load_prog();
    @(negedge clk); start = 1'b1; stall = 1'b0;
    @(negedge clk); start = 1'b0;
    n = 0; idx = 0; st_prev = 0; prev_w = word_out;
    while (!halted && n < 60000) begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (st_prev) chk(!word_valid && word_out == prev_w, "R6", int'(word_out), int'(prev_w));
      if (word_valid && seq_chk) begin
        if (idx < n_exp) chk(word_out == exp_w[idx], "R2", int'(word_out), int'(exp_w[idx]));
        else chk(1'b0, "R3", idx, n_exp);
        idx++;
      end
      prev_w = word_out;
      st_prev = stall_en && ($urandom % 4 == 0);
      stall = st_prev;
      if (mid_start && n == 37) start = 1'b1;
    end
    stall = 1'b0; start = 1'b0;
    chk(halted, "R7", int'(halted), 1);
    if (seq_chk) chk(idx == n_exp, "R3", idx, n_exp);
    if (cyc_chk) chk(n == n_exp + n_loops + 1, "R3", n, n_exp + n_loops + 1);
    repeat (3) begin
      @(negedge clk);
      chk(!word_valid && halted, "R7", int'(word_valid), 0);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    chk(!word_valid, "R8", int'(word_valid), 0);
    chk(!halted, "R8", int'(halted), 0);
    chk(!stack_err, "R8", int'(stack_err), 0);
    chk(word_out == 8'd0, "R8", int'(word_out), 0);

    // shared-label example program (R4), then with a start pulse mid-run (R1)
    clear_prog();
    put(0, 2, 10, 8); put(1, 2, 4, 4); put(2, 1, 1, 8'h0C); put(3, 1, 5, 8'h04);
    put(4, 1, 24, 8'h06); put(5, 2, 16, 8); put(6, 1, 1, 8'h09); put(7, 1, 5, 8'h00);
    put(8, 1, 24, 8'h02); put(9, 0, 0, 0);
    run_prog(0, 1, 1, 1);
    chk(n_exp == 6000, "R4", n_exp, 6000);
    run_prog(1, 0, 0, 1);

    // randomised variants of the shared-label shape, some stalled
    for (int it = 0; it < 20; it++) begin
      clear_prog();
      put(0, 2, $urandom % 4, 8); put(1, 2, $urandom % 4, 4);
      put(2, 1, $urandom % 5, $urandom % 256); put(3, 1, $urandom % 5, $urandom % 256);
      put(4, 1, $urandom % 5, $urandom % 256); put(5, 2, $urandom % 4, 8);
      put(6, 1, $urandom % 5, $urandom % 256); put(7, 1, $urandom % 5, $urandom % 256);
      put(8, 1, $urandom % 5, $urandom % 256); put(9, 0, 0, 0);
      run_prog(it[0], !it[0], 0, 1);
    end

    // zero counts act as one (R2, R3)
    clear_prog();
    put(0, 1, 0, 8'hAA); put(1, 2, 0, 2); put(2, 1, 3, 8'h55); put(3, 0, 0, 0);
    run_prog(0, 1, 0, 1);
    chk(n_exp == 4, "R2", n_exp, 4);

    // five-deep nesting fills the stack exactly (R5)
    clear_prog();
    for (int i = 0; i < 5; i++) put(i, 2, 2, 9 - i);
    for (int i = 5; i < 10; i++) put(i, 1, 1 + (i % 3), 16 * i + 1);
    put(10, 0, 0, 0);
    run_prog(0, 1, 0, 1);
    chk(!stack_err && !m_ovf, "R5", int'(stack_err), 0);

    // six-deep nesting overflows the stack (R5)
    clear_prog();
    for (int i = 0; i < 6; i++) put(i, 2, 1, 11 - i);
    for (int i = 6; i < 12; i++) put(i, 1, 1, i);
    put(12, 0, 0, 0);
    run_prog(0, 0, 0, 0);
    chk(stack_err == 1'b1, "R5", int'(stack_err), 1);

    // sticky across a clean run, and that run is unaffected
    clear_prog();
    put(0, 2, 3, 2); put(1, 1, 2, 8'h11); put(2, 1, 1, 8'h22); put(3, 0, 0, 0);
    run_prog(1, 0, 0, 1);
    chk(stack_err == 1'b1, "R5", int'(stack_err), 1);

    do_reset();
    @(negedge clk);
    chk(!stack_err && !halted, "R8", int'(stack_err), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule